// File: doc/BRIEF.md
# Input Change-of-State Detector

This block watches a small group of general-purpose input pins and presents them in one status byte. The upper half holds sticky change flags, one per pin, and the lower half shows the present synchronized level of each pin. A pin change counts only after it has been filtered. Each pin first passes through a two-flop synchronizer. It is then sampled on a slow, externally generated sample tick. A new level is accepted only when two consecutive tick samples agree on it and it differs from the last accepted level. A change that is accepted therefore needed to stay stable for between one and two tick periods.

Each pin has its own detector enable. A read strobe from the processor clears every flag in the byte. One aggregate output is high while any flag is set, and it feeds an interrupt status bit elsewhere in the chip. If a change is accepted in the same cycle as a clearing read, that change still leaves its flag set, so no event is lost. The first tick after reset only takes the current pin levels as the reference and raises no flag.

Top module: `pin_change_monitor`

## Requirements
- R1: `status_o[4+i]` is the change flag of pin i and `status_o[i]` is pin i's level after a two-flop synchronizer, with no further latching. Encoding: 1 = set / high.
- R2: An accepted transition sets the pin's flag whether the pin went low-to-high or high-to-low.
- R3: A new level is accepted only at a tick where the synchronized level equals the one sampled at the previous tick and differs from the accepted level. A level seen at a single tick only is rejected, and without ticks no flag sets.
- R4: With `det_en_i[i]` = 0, flag i never sets. The accepted level of pin i still follows the pin, so enabling the pin later raises no flag for an old change.
- R5: A cycle with `rd_strobe_i` = 1 clears all flags on the next clock edge, unless a change is accepted in that same cycle.
- R6: `change_any_o` is 1 exactly when at least one flag is set.
- R7: After reset all flags are clear. The first tick after reset loads the present pin levels as the reference without setting any flag.
- R8: When a change is accepted in the same cycle as a clearing read, the flag for that change is set after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | NPINS | Asynchronous input pins |
| sample_tick_i | input | 1 | One-cycle sampling pulse from the slow tick generator |
| det_en_i | input | NPINS | Per-pin detector enable |
| rd_strobe_i | input | 1 | Status read strobe; clears flags |
| status_o | output | 2*NPINS | {change flags, synchronized pin levels} |
| change_any_o | output | 1 | OR of all change flags |

## Verification
The bench builds the block with the default NPINS = 4, which fills the 8-bit status layout the requirements describe. With four pins, one vector can change several pins at once in mixed directions, can enable only some of the pins, and can hold a short glitch on one pin while the others stay still. The tick is driven directly by the bench, so single-tick glitches, the two-tick acceptance point, and a tick that lands together with a read can each be placed in an exact cycle.

// File: rtl/pin_change_monitor.sv
module pin_change_monitor #(
  parameter int NPINS = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NPINS-1:0]   pin_i,
  input  logic               sample_tick_i,
  input  logic [NPINS-1:0]   det_en_i,
  input  logic               rd_strobe_i,
  output logic [2*NPINS-1:0] status_o,
  output logic               change_any_o
);

  logic [NPINS-1:0] sync1_q, sync2_q, prev_q, conf_q, flag_q;
  logic             primed_q;
  logic [NPINS-1:0] accept;

  assign accept = (sample_tick_i && primed_q) ? (~(sync2_q ^ prev_q) & (sync2_q ^ conf_q))
                                              : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q  <= '0;
      sync2_q  <= '0;
      prev_q   <= '0;
      conf_q   <= '0;
      flag_q   <= '0;
      primed_q <= 1'b0;
    end else begin
      sync1_q <= pin_i;
      sync2_q <= sync1_q;
      if (sample_tick_i) begin
        prev_q   <= sync2_q;
        primed_q <= 1'b1;
        conf_q   <= primed_q ? (conf_q ^ accept) : sync2_q;
      end
      flag_q <= (flag_q & {NPINS{~rd_strobe_i}}) | (accept & det_en_i);
    end
  end

  assign status_o     = {flag_q, sync2_q};
  assign change_any_o = |flag_q;

endmodule

module pin_change_monitor_chk #(
  parameter int NPINS = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               sample_tick_i,
  input logic               rd_strobe_i,
  input logic [NPINS-1:0]   det_en_i,
  input logic [2*NPINS-1:0] status_o,
  input logic               change_any_o
);

  a_r6_any_matches_flags: assert property (@(posedge clk) disable iff (!rst_n)
    change_any_o == (status_o[2*NPINS-1:NPINS] != '0));

  a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe_i && !sample_tick_i) |=> (status_o[2*NPINS-1:NPINS] == '0));

  a_r3_no_tick_no_set: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_tick_i |=> ((status_o[2*NPINS-1:NPINS] & ~$past(status_o[2*NPINS-1:NPINS])) == '0));

  a_r4_disabled_never_sets: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_o[2*NPINS-1:NPINS] & ~$past(status_o[2*NPINS-1:NPINS])
               & ~$past(det_en_i)) == '0));

  a_r7_flags_hold_without_event: assert property (@(posedge clk) disable iff (!rst_n)
    (!sample_tick_i && !rd_strobe_i) |=> $stable(status_o[2*NPINS-1:NPINS]));

endmodule

bind pin_change_monitor pin_change_monitor_chk #(.NPINS(NPINS)) chk_i (
  .clk(clk), .rst_n(rst_n), .sample_tick_i(sample_tick_i), .rd_strobe_i(rd_strobe_i),
  .det_en_i(det_en_i), .status_o(status_o), .change_any_o(change_any_o)
);

// File: tb/pin_change_monitor_tb_top.sv
module pin_change_monitor_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] pin = '0;
  logic       tick = 1'b0;
  logic [3:0] en = '0;
  logic       rd = 1'b0;
  logic [7:0] status;
  logic       any;
  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pin_change_monitor #(.NPINS(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .pin_i(pin), .sample_tick_i(tick),
    .det_en_i(en), .rd_strobe_i(rd), .status_o(status), .change_any_o(any)
  );

  // {pins, en, rd, ticks, expected status}
  localparam logic [23:0] VEC [13] = '{
    {4'h1, 4'hF, 4'h0, 4'h2, 8'h11},  // R2 rise on pin0, R1 layout
    {4'h1, 4'hF, 4'h1, 4'h0, 8'h01},  // R5 read clears
    {4'h0, 4'hF, 4'h0, 4'h1, 8'h00},  // R3 one tick not enough
    {4'h0, 4'hF, 4'h0, 4'h1, 8'h10},  // R2 fall accepted at second tick
    {4'h0, 4'hF, 4'h1, 4'h0, 8'h00},  // R5
    {4'hA, 4'h2, 4'h0, 4'h2, 8'h2A},  // R4 only pin1 enabled
    {4'hA, 4'hF, 4'h1, 4'h2, 8'h0A},  // R4 no stale flag on pin3
    {4'h5, 4'hF, 4'h0, 4'h2, 8'hF5},  // R2 mixed directions
    {4'h5, 4'hF, 4'h1, 4'h0, 8'h05},  // R5
    {4'hD, 4'hF, 4'h0, 4'h1, 8'h0D},  // R1 live level, R3 glitch start
    {4'h5, 4'hF, 4'h0, 4'h1, 8'h05},  // R3 glitch rejected
    {4'h4, 4'hF, 4'h0, 4'h0, 8'h04},  // R3 no tick, no flag
    {4'h4, 4'hF, 4'h0, 4'h2, 8'h14}   // R3 accepted after two ticks
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clocks(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic pulse_tick();
    tick = 1'b1; @(negedge clk); tick = 1'b0;
  endtask

  task automatic pulse_read();
    rd = 1'b1; @(negedge clk); rd = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    en = 4'hF;
    clocks(3);
    rst_n = 1'b1;
    clocks(3);
    check("R7 reset status", status, 8'h00);
    check("R6 reset any", {7'd0, any}, 8'h00);
    pulse_tick();

    for (int v = 0; v < 13; v++) begin
      pin = VEC[v][23:20];
      en  = VEC[v][19:16];
      clocks(3);
      if (VEC[v][12]) pulse_read();
      for (int t = 0; t < int'(VEC[v][11:8]); t++) pulse_tick();
      check($sformatf("vec %0d R1 R2 R3 R4 R5", v), status, VEC[v][7:0]);
      check($sformatf("vec %0d R6", v), {7'd0, any}, {7'd0, VEC[v][7:4] != 4'h0});
    end

    // R8: acceptance and read in the same cycle; pin0 flag from before is cleared
    pin = 4'h6;
    clocks(3);
    pulse_tick();
    check("R8 setup", status, 8'h16);
    tick = 1'b1; rd = 1'b1;
    @(negedge clk);
    tick = 1'b0; rd = 1'b0;
    check("R8 set wins over clear", status, 8'h26);
    pulse_read();
    check("R5 clear after R8", status, 8'h06);

    // R7: pins high through reset, first tick only primes
    pin = 4'hF;
    rst_n = 1'b0;
    clocks(2);
    rst_n = 1'b1;
    clocks(3);
    check("R7 levels after reset", status, 8'h0F);
    pulse_tick();
    pulse_tick();
    pulse_tick();
    check("R7 priming raises no flag", status, 8'h0F);
    check("R6 any low after priming", {7'd0, any}, 8'h00);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule